// File: doc/BRIEF.md
# Descriptor Fetch and Chaining Sequencer

This block runs one DMA channel from its first request to the end of its last chained block. When a gated request arrives and the channel is idle, the block reads an eight-word transfer descriptor from a small internal RAM. The descriptor number comes from the channel's mode setting. The fetch takes two clocks per word, sixteen clocks in total, and the block does not request the bus while it runs. When the fetch is complete, the block raises a bus request. It marks the channel as transferring only after the bus is granted. The full descriptor is presented on a flat output bus for the data mover.

When the data mover reports that the block is finished, the sequencer emits a one-cycle done pulse and then makes a decision. If the channel's chaining mode is on and the descriptor is flagged as chained, it fetches the next descriptor and carries on. Otherwise it emits a chain-finished pulse and returns to idle. Every RAM word carries its own parity bit, and a bad word halts the channel in an error state until software clears it. A deactivation write takes effect only while the channel waits for the bus or sits between chained blocks.

Top module: `dma_chain_seq`

## Requirements
- R1: A descriptor fetch keeps `fetch_busy` high for exactly 16 consecutive cycles, which is two per word for eight words. `bus_req` stays low during the fetch.
- R2: A fetch starts only from idle, in the cycle after a gated request, and uses the descriptor number on `desc_sel`. Descriptor d word w lives at RAM address d*8+w. After the fetch, word w appears on `desc_out[16w+15:16w]`.
- R3: `bus_req` rises in the cycle after the fetch ends. `xfer_active` rises only in the cycle after `bus_grant` is sampled high while the channel waits for the bus.
- R4: A `xfer_done` during a transfer gives a one-cycle `blk_done` pulse. If `chain_mode` is high and bit 15 of descriptor word 0 is set, one pending cycle follows, and then a fetch of descriptor number plus one, which wraps to 0 after the last descriptor.
- R5: If either chaining condition is missing, `chain_end` pulses in the same cycle as `blk_done` and the channel returns to idle.
- R6: RAM bit 16 is odd parity over bits 15:0, so a good word has an odd count of ones across all 17 bits. A bad word ends the fetch, sets `par_err`, and holds `bus_req` low. The channel stays stopped until `err_clr`, which clears `par_err` and returns it to idle.
- R7: `deact_wr` returns the channel to idle while it is waiting for the bus or pending a chain. It has no effect during a fetch or a transfer.
- R8: When `req_mask` is high, `ext_req` is ignored, but `sw_req` still starts a fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ram_we | input | 1 | Descriptor RAM write enable |
| ram_waddr | input | 7 | RAM write address (descriptor*8 + word) |
| ram_wdata | input | 17 | RAM write data, bit 16 is parity |
| ext_req | input | 1 | External transfer request |
| sw_req | input | 1 | Software transfer request |
| req_mask | input | 1 | Blocks external requests when high |
| chain_mode | input | 1 | Channel chaining mode enable |
| desc_sel | input | 4 | First descriptor number |
| deact_wr | input | 1 | Channel deactivation write |
| err_clr | input | 1 | Clears the parity error state |
| bus_grant | input | 1 | Bus granted to this channel |
| xfer_done | input | 1 | Data mover reports block complete |
| bus_req | output | 1 | Bus request |
| xfer_active | output | 1 | Channel owns the bus and transfers |
| fetch_busy | output | 1 | Descriptor fetch in progress |
| blk_done | output | 1 | One-cycle end-of-block pulse |
| chain_end | output | 1 | One-cycle end-of-chain pulse |
| par_err | output | 1 | Parity error, channel stopped |
| desc_out | output | 128 | Fetched descriptor, word w at bits 16w+15:16w |

## Verification
The bench counts fetch cycles exactly and watches `bus_req` during each of them. An off-by-one counter, or a request raised early, would show up as a wrong length or a high bus request mid-fetch. It chains from the last descriptor to confirm the index wraps to 0; a design that fails to wrap would present the wrong word 0. It tries each chaining condition alone to catch a design that tests only one of them. It sends deactivation in all four active states: ignoring it where it is allowed leaves the channel fetching or requesting, and accepting it where it is not drops the transfer. It corrupts a mid-descriptor word to confirm the channel halts without ever requesting the bus.

// File: rtl/dcs_pkg.sv
// Shared types for the descriptor fetch and chaining sequencer.
// Assumes a single channel per instance.
package dcs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WAIT_BUS,
        ST_XFER,
        ST_PEND_CHAIN,
        ST_ERROR
    } chan_state_t;
endpackage

// File: rtl/dcs_desc_ram.sv
// Descriptor storage: one write port and one registered read port.
// Each word holds data plus a parity bit. Contents are not reset.
module dcs_desc_ram #(
    parameter int DEPTH  = 128,
    parameter int RAM_W  = 17,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [RAM_W-1:0]  wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [RAM_W-1:0]  rdata
);
    logic [RAM_W-1:0] mem [DEPTH];

    // Store written words.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Registered read, data valid one cycle after the address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else begin
            rdata <= mem[raddr];
        end
    end
endmodule

// File: rtl/dcs_fetch.sv
// Descriptor fetch engine. A start pulse latches a descriptor number.
// The engine then walks its words, spending one cycle on the address
// and one on capture for each word. It checks odd parity on every word
// and stops early on a mismatch. It assumes a RAM with a single-cycle
// registered read.
module dcs_fetch #(
    parameter int IDX_W      = 4,
    parameter int WORD_W     = 16,
    parameter int DESC_WORDS = 8,
    localparam int WSEL_W    = $clog2(DESC_WORDS),
    localparam int CNT_W     = WSEL_W + 1,
    localparam int ADDR_W    = IDX_W + WSEL_W,
    localparam int RAM_W     = WORD_W + 1,
    localparam int DESC_BITS = WORD_W * DESC_WORDS,
    localparam int LAST_CNT  = 2 * DESC_WORDS - 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [IDX_W-1:0]     start_idx,
    output logic [ADDR_W-1:0]    rd_addr,
    input  logic [RAM_W-1:0]     rd_data,
    output logic                 busy,
    output logic                 last,
    output logic                 bad,
    output logic [DESC_BITS-1:0] desc
);
    logic [CNT_W-1:0]  cnt;
    logic [IDX_W-1:0]  idx;
    logic              capture;
    logic              word_ok;
    logic [WSEL_W-1:0] wsel;

    assign wsel    = cnt[CNT_W-1:1];
    assign rd_addr = {idx, wsel};
    assign capture = busy & cnt[0];
    assign word_ok = ^rd_data;
    assign bad     = capture & ~word_ok;
    assign last    = capture & word_ok & (cnt == CNT_W'(LAST_CNT));

    // Sequence the fetch: latch the index, count cycles, stop at the end or on an error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
            idx  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= '0;
            idx  <= start_idx;
        end else if (busy) begin
            if (bad || last) begin
                busy <= 1'b0;
            end
            cnt <= cnt + 1'b1;
        end
    end

    // Capture each good word into its slot of the descriptor.
    for (genvar w = 0; w < DESC_WORDS; w++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                desc[w*WORD_W +: WORD_W] <= '0;
            end else if (capture && word_ok && wsel == WSEL_W'(w)) begin
                desc[w*WORD_W +: WORD_W] <= rd_data[WORD_W-1:0];
            end
        end
    end

    // R1
    fetch_begin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt == '0) |-> $past(start));

    // R6
    bad_word_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad |=> !busy);
endmodule

// File: rtl/dcs_chain_fsm.sv
// Channel state machine. It starts fetches, raises the bus request,
// tracks the transfer, decides on chaining and accepts deactivation
// only in the allowed states. It assumes the fetch engine reports the
// last good word or a bad word combinationally, in the cycle they are
// captured.
module dcs_chain_fsm
    import dcs_pkg::*;
#(
    parameter int NUM_DESC = 16,
    localparam int IDX_W   = $clog2(NUM_DESC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_ok,
    input  logic             chain_mode,
    input  logic [IDX_W-1:0] desc_sel,
    input  logic             deact_wr,
    input  logic             err_clr,
    input  logic             bus_grant,
    input  logic             xfer_done,
    input  logic             fetch_last,
    input  logic             fetch_bad,
    input  logic             chained_flag,
    output logic             fetch_start,
    output logic [IDX_W-1:0] fetch_idx,
    output logic             bus_req,
    output logic             xfer_active,
    output logic             blk_done,
    output logic             chain_end,
    output logic             par_err
);
    chan_state_t      state, nxt;
    logic [IDX_W-1:0] cur_idx;
    logic [IDX_W-1:0] chain_idx;
    logic             go_chain;
    logic             finish;

    assign chain_idx = (cur_idx == IDX_W'(NUM_DESC - 1)) ? '0 : cur_idx + 1'b1;
    assign go_chain  = chain_mode & chained_flag;
    assign finish    = (state == ST_XFER) & xfer_done;

    // Next-state and fetch-start decode.
    always_comb begin
        nxt         = state;
        fetch_start = 1'b0;
        fetch_idx   = desc_sel;
        case (state)
            ST_IDLE: begin
                if (req_ok) begin
                    nxt         = ST_FETCH;
                    fetch_start = 1'b1;
                end
            end
            ST_FETCH: begin
                if (fetch_bad) begin
                    nxt = ST_ERROR;
                end else if (fetch_last) begin
                    nxt = ST_WAIT_BUS;
                end
            end
            ST_WAIT_BUS: begin
                if (deact_wr) begin
                    nxt = ST_IDLE;
                end else if (bus_grant) begin
                    nxt = ST_XFER;
                end
            end
            ST_XFER: begin
                if (xfer_done) begin
                    nxt = go_chain ? ST_PEND_CHAIN : ST_IDLE;
                end
            end
            ST_PEND_CHAIN: begin
                if (deact_wr) begin
                    nxt = ST_IDLE;
                end else begin
                    nxt         = ST_FETCH;
                    fetch_start = 1'b1;
                    fetch_idx   = chain_idx;
                end
            end
            ST_ERROR: begin
                if (err_clr) begin
                    nxt = ST_IDLE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // State, current descriptor number and registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            cur_idx     <= '0;
            bus_req     <= 1'b0;
            xfer_active <= 1'b0;
            blk_done    <= 1'b0;
            chain_end   <= 1'b0;
            par_err     <= 1'b0;
        end else begin
            state       <= nxt;
            if (fetch_start) begin
                cur_idx <= fetch_idx;
            end
            bus_req     <= (nxt == ST_WAIT_BUS) || (nxt == ST_XFER);
            xfer_active <= (nxt == ST_XFER);
            blk_done    <= finish;
            chain_end   <= finish & ~go_chain;
            par_err     <= (nxt == ST_ERROR);
        end
    end

    // R3
    grant_before_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_active) |-> $past(bus_grant));

    // R4
    done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done |=> !blk_done);

    // R6
    err_no_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        par_err |-> !bus_req);

    // R7
    deact_in_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_XFER && deact_wr && !xfer_done) |=> xfer_active);

    // R5
    end_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chain_end |-> blk_done);
endmodule

// File: rtl/dma_chain_seq.sv
// Top of the per-channel descriptor fetch and chaining sequencer.
// It gates requests, then connects the descriptor RAM, the fetch engine
// and the channel state machine. Word 0 bit 15 of the fetched descriptor
// is the chained flag. It assumes one channel per instance.
module dma_chain_seq #(
    parameter int NUM_DESC   = 16,
    parameter int DESC_WORDS = 8,
    parameter int WORD_W     = 16,
    localparam int IDX_W     = $clog2(NUM_DESC),
    localparam int WSEL_W    = $clog2(DESC_WORDS),
    localparam int ADDR_W    = IDX_W + WSEL_W,
    localparam int RAM_W     = WORD_W + 1,
    localparam int DESC_BITS = WORD_W * DESC_WORDS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ram_we,
    input  logic [ADDR_W-1:0]    ram_waddr,
    input  logic [RAM_W-1:0]     ram_wdata,
    input  logic                 ext_req,
    input  logic                 sw_req,
    input  logic                 req_mask,
    input  logic                 chain_mode,
    input  logic [IDX_W-1:0]     desc_sel,
    input  logic                 deact_wr,
    input  logic                 err_clr,
    input  logic                 bus_grant,
    input  logic                 xfer_done,
    output logic                 bus_req,
    output logic                 xfer_active,
    output logic                 fetch_busy,
    output logic                 blk_done,
    output logic                 chain_end,
    output logic                 par_err,
    output logic [DESC_BITS-1:0] desc_out
);
    logic              req_ok;
    logic              f_start;
    logic [IDX_W-1:0]  f_idx;
    logic [ADDR_W-1:0] rd_addr;
    logic [RAM_W-1:0]  rd_data;
    logic              f_last;
    logic              f_bad;

    // The mask blocks only external requests.
    assign req_ok = (ext_req & ~req_mask) | sw_req;

    dcs_desc_ram #(
        .DEPTH (NUM_DESC * DESC_WORDS),
        .RAM_W (RAM_W)
    ) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    dcs_fetch #(
        .IDX_W      (IDX_W),
        .WORD_W     (WORD_W),
        .DESC_WORDS (DESC_WORDS)
    ) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (f_start),
        .start_idx (f_idx),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .busy      (fetch_busy),
        .last      (f_last),
        .bad       (f_bad),
        .desc      (desc_out)
    );

    dcs_chain_fsm #(
        .NUM_DESC (NUM_DESC)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_ok       (req_ok),
        .chain_mode   (chain_mode),
        .desc_sel     (desc_sel),
        .deact_wr     (deact_wr),
        .err_clr      (err_clr),
        .bus_grant    (bus_grant),
        .xfer_done    (xfer_done),
        .fetch_last   (f_last),
        .fetch_bad    (f_bad),
        .chained_flag (desc_out[WORD_W-1]),
        .fetch_start  (f_start),
        .fetch_idx    (f_idx),
        .bus_req      (bus_req),
        .xfer_active  (xfer_active),
        .blk_done     (blk_done),
        .chain_end    (chain_end),
        .par_err      (par_err)
    );

    // R1
    no_bus_in_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_busy |-> !bus_req);

    // R8
    masked_ext_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_busy && !bus_req && !par_err && !xfer_active && !blk_done
         && ext_req && req_mask && !sw_req) |=> !($rose(fetch_busy) && !$past(sw_req)));
endmodule

// File: tb/tb_dma_chain_seq.sv
module tb_dma_chain_seq;
    localparam int NDESC = 16;
    localparam int NW    = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ram_we = 1'b0;
    logic [6:0]   ram_waddr = '0;
    logic [16:0]  ram_wdata = '0;
    logic         ext_req = 1'b0, sw_req = 1'b0, req_mask = 1'b0;
    logic         chain_mode = 1'b0;
    logic [3:0]   desc_sel = '0;
    logic         deact_wr = 1'b0, err_clr = 1'b0;
    logic         bus_grant = 1'b0, xfer_done = 1'b0;
    logic         bus_req, xfer_active, fetch_busy, blk_done, chain_end, par_err;
    logic [127:0] desc_out;

    int tests = 0;
    int fails = 0;
    logic [15:0] exp_mem [NDESC*NW];

    // {req_mask, ext_req, sw_req, fetch expected}
    localparam logic [3:0] VEC [6] = '{4'b0000, 4'b0101, 4'b1100, 4'b1011, 4'b0011, 4'b1111};

    always #10 clk = ~clk;

    dma_chain_seq dut (
        .clk(clk), .rst_n(rst_n), .ram_we(ram_we), .ram_waddr(ram_waddr),
        .ram_wdata(ram_wdata), .ext_req(ext_req), .sw_req(sw_req),
        .req_mask(req_mask), .chain_mode(chain_mode), .desc_sel(desc_sel),
        .deact_wr(deact_wr), .err_clr(err_clr), .bus_grant(bus_grant),
        .xfer_done(xfer_done), .bus_req(bus_req), .xfer_active(xfer_active),
        .fetch_busy(fetch_busy), .blk_done(blk_done), .chain_end(chain_end),
        .par_err(par_err), .desc_out(desc_out)
    );

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_word(input int addr, input logic [15:0] d, input bit good);
        ram_we    = 1'b1;
        ram_waddr = 7'(addr);
        ram_wdata = {good ? ~^d : ^d, d};
        exp_mem[addr] = d;
        @(negedge clk);
        ram_we = 1'b0;
    endtask

    function automatic logic [127:0] exp_desc(input int d);
        logic [127:0] v = '0;
        for (int w = 0; w < NW; w++) v[w*16 +: 16] = exp_mem[d*NW + w];
        return v;
    endfunction

    task automatic pulse_req(input logic m, input logic e, input logic s);
        req_mask = m; ext_req = e; sw_req = s;
        @(negedge clk);
        ext_req = 1'b0; sw_req = 1'b0;
    endtask

    // Counts fetch cycles from the current negedge and checks bus_req stays low (R1).
    task automatic run_fetch(output int n);
        int hi = 0;
        n = 0;
        while (fetch_busy && n < 40) begin
            if (bus_req) hi++;
            n++;
            @(negedge clk);
        end
        chk(hi == 0, "R1 bus_req during fetch", 128'(hi), 128'd0);
    endtask

    task automatic grant_now();
        bus_grant = 1'b1;
        @(negedge clk);
        bus_grant = 1'b0;
    endtask

    task automatic done_now();
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        chk({bus_req, xfer_active, fetch_busy, blk_done, chain_end, par_err} == 6'b0,
            "reset outputs", 128'({bus_req, xfer_active, fetch_busy, blk_done, chain_end, par_err}), 128'd0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int d = 0; d < NDESC; d++)
            for (int w = 0; w < NW; w++)
                wr_word(d*NW + w, {1'b0, 3'(w), 4'(d), 8'h3C ^ 8'(d*7)}, 1'b1);

        // Vector walk: request gating (R8), fetch length (R1), descriptor (R2), bus (R3), end (R5)
        for (int i = 0; i < 6; i++) begin
            desc_sel = 4'(i + 1);
            pulse_req(VEC[i][3], VEC[i][2], VEC[i][1]);
            chk(fetch_busy == VEC[i][0], "R8 R2 request gating", 128'(fetch_busy), 128'(VEC[i][0]));
            if (VEC[i][0]) begin
                run_fetch(n);
                chk(n == 16, "R1 fetch length", 128'(n), 128'd16);
                chk(desc_out == exp_desc(i + 1), "R2 descriptor contents", desc_out, exp_desc(i + 1));
                chk(bus_req && !xfer_active, "R3 request before grant", 128'({bus_req, xfer_active}), 128'b10);
                @(negedge clk);
                chk(!xfer_active, "R3 no transfer without grant", 128'(xfer_active), 128'd0);
                grant_now();
                chk(xfer_active, "R3 transfer after grant", 128'(xfer_active), 128'd1);
                done_now();
                chk(blk_done && chain_end, "R5 unchained end", 128'({blk_done, chain_end}), 128'b11);
                @(negedge clk);
                chk(!blk_done && !bus_req, "R4 done pulse one cycle", 128'({blk_done, bus_req}), 128'b00);
            end
        end

        // Chaining with wrap 15 -> 0 (R4)
        wr_word(15*NW, exp_mem[15*NW] | 16'h8000, 1'b1);
        chain_mode = 1'b1; desc_sel = 4'd15;
        pulse_req(1'b0, 1'b0, 1'b1);
        run_fetch(n);
        grant_now();
        done_now();
        chk(blk_done && !chain_end, "R4 chained block end", 128'({blk_done, chain_end}), 128'b10);
        @(negedge clk);
        chk(fetch_busy, "R4 chained fetch starts", 128'(fetch_busy), 128'd1);
        run_fetch(n);
        chk(n == 16, "R1 R4 chained fetch length", 128'(n), 128'd16);
        chk(desc_out == exp_desc(0), "R4 wrapped to descriptor 0", desc_out, exp_desc(0));
        grant_now();
        done_now();
        chk(chain_end, "R5 chain_mode set, flag clear", 128'(chain_end), 128'd1);

        // Flag set but chaining mode off (R5)
        chain_mode = 1'b0;
        pulse_req(1'b0, 1'b0, 1'b1);
        run_fetch(n);
        grant_now();
        done_now();
        chk(chain_end, "R5 flag set, chain_mode clear", 128'(chain_end), 128'd1);
        @(negedge clk);
        chk(!fetch_busy, "R5 back to idle", 128'(fetch_busy), 128'd0);

        // Deactivation in pending chain (R7)
        chain_mode = 1'b1;
        pulse_req(1'b0, 1'b0, 1'b1);
        run_fetch(n);
        grant_now();
        done_now();
        deact_wr = 1'b1;
        @(negedge clk);
        deact_wr = 1'b0;
        @(negedge clk);
        chk(!fetch_busy && !bus_req, "R7 deact in pending chain", 128'({fetch_busy, bus_req}), 128'b00);

        // Deactivation ignored during fetch, honoured while waiting for bus (R7)
        chain_mode = 1'b0; desc_sel = 4'd3;
        pulse_req(1'b0, 1'b1, 1'b0);
        deact_wr = 1'b1;
        @(negedge clk);
        deact_wr = 1'b0;
        run_fetch(n);
        chk(n == 15 && bus_req, "R7 deact ignored in fetch", 128'({n[7:0], bus_req}), 128'({8'd15, 1'b1}));
        deact_wr = 1'b1;
        @(negedge clk);
        deact_wr = 1'b0;
        chk(!bus_req, "R7 deact while waiting for bus", 128'(bus_req), 128'd0);
        bus_grant = 1'b1;
        @(negedge clk);
        bus_grant = 1'b0;
        chk(!xfer_active, "R7 idle after deact", 128'(xfer_active), 128'd0);

        // Deactivation ignored during transfer (R7)
        pulse_req(1'b0, 1'b1, 1'b0);
        run_fetch(n);
        grant_now();
        deact_wr = 1'b1;
        @(negedge clk);
        deact_wr = 1'b0;
        chk(xfer_active && bus_req, "R7 deact ignored in transfer", 128'({xfer_active, bus_req}), 128'b11);
        done_now();

        // Parity error halts the channel (R6)
        wr_word(5*NW + 3, exp_mem[5*NW + 3], 1'b0);
        desc_sel = 4'd5;
        pulse_req(1'b0, 1'b0, 1'b1);
        begin
            int hi = 0;
            for (int k = 0; k < 20; k++) begin
                if (bus_req) hi++;
                @(negedge clk);
            end
            chk(hi == 0, "R6 no bus_req on bad word", 128'(hi), 128'd0);
        end
        chk(par_err && !fetch_busy, "R6 error flag set", 128'({par_err, fetch_busy}), 128'b10);
        pulse_req(1'b0, 1'b0, 1'b1);
        chk(par_err && !fetch_busy, "R6 stays stopped", 128'({par_err, fetch_busy}), 128'b10);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        chk(!par_err, "R6 cleared", 128'(par_err), 128'd0);
        desc_sel = 4'd6;
        pulse_req(1'b0, 1'b0, 1'b1);
        chk(fetch_busy, "R6 idle after clear", 128'(fetch_busy), 128'd1);
        run_fetch(n);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule